// File: doc/BRIEF.md
# Interrupt and Trap Delegation Register Bank

This block keeps the machine-level interrupt enable, interrupt pending and interrupt delegation registers. It also keeps the exception delegation register and the two trap-vector base registers, one for machine mode and one for supervisor mode. It serves one read-modify-write access per cycle. The access carries a register select, a data word and a bit mask. The block returns the value the selected register held before the access, and it applies the merge `(old & ~mask) | (data & mask)` together with the legalization rules of that register.

The supervisor interrupt enable and pending registers hold no state of their own. Each one is a view of the machine register, seen through the delegation mask. Interrupt lines driven by hardware are taken in through a claim mask. A claimed pending bit copies its input line on every clock edge, and software cannot change it. The registered values are driven out so that the priority and trap-entry logic can use them.

Top module: `irq_csr_bank`

## Requirements
- R1: After the asynchronous reset every register reads 0. While the claim mask is zero, every select reads 0 until the first write.
- R2: An access drives rdata_o combinationally with the selected register's pre-access value. On the next edge the register takes the merged value `(old & ~wmask_i) | (wdata_i & wmask_i)`, after its own legalization. With req_i low nothing changes. The select codes are 0 machine enable, 1 machine pending, 2 interrupt delegation, 3 supervisor enable, 4 supervisor pending, 5 exception delegation, 6 machine vector and 7 supervisor vector.
- R3: The interrupt delegation register accepts writes only on bits 1, 5 and 9 (the supervisor software, timer and external interrupts). Its other bits always read 0.
- R4: The machine enable register accepts writes only on bits 1, 3, 5, 7, 9 and 11. Its other bits stay 0.
- R5: A software write to machine pending changes only the bits that are set in wmask_i, are among bits 1, 5 and 9, and are clear in claim_i.
- R6: Every bit that is set in claim_i loads hw_pend_i on each clock edge, on any bit position, whether or not an access is present. In the same cycle a claimed bit ignores a software write.
- R7: A supervisor pending access writes only the bits that meet the R5 conditions, are set in the delegation register, and are among bits 0, 1 and 8. In effect this leaves only bit 1. It returns pending AND delegation.
- R8: A supervisor enable access returns enable AND delegation. Its write changes only delegated bits of the machine enable register, and the R4 mask still applies.
- R9: In both vector registers, a merged value whose two low bits equal 2 or 3 is discarded. Any other merged value is stored whole.
- R10: The exception delegation register accepts writes only on bits 0 to 13 and bit 15. Bit 14 and all bits above 15 stay 0.
- R11: A select code of 8 or above returns 0 and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe |
| sel_i | input | 4 | Register select |
| wdata_i | input | XLEN | Write data |
| wmask_i | input | XLEN | Write bit mask |
| rdata_o | output | XLEN | Pre-access value of the selected register |
| hw_pend_i | input | XLEN | Interrupt lines driven by hardware |
| claim_i | input | XLEN | Pending bits owned by hardware |
| mie_o | output | XLEN | Machine enable register |
| mip_o | output | XLEN | Machine pending register |
| mideleg_o | output | XLEN | Interrupt delegation register |
| medeleg_o | output | XLEN | Exception delegation register |
| mtvec_o | output | XLEN | Machine trap vector |
| stvec_o | output | XLEN | Supervisor trap vector |

## Verification
The bench builds the block with XLEN at its default of 32. At that width, an all-ones write mask also reaches the upper sixteen bits, where every register must stay at zero, and it reaches the illegal bit 14 of the exception delegation register. Claim patterns are aimed at delegable bits and at non-delegable bits. These patterns show that hardware ownership both overrides software writes and stays hidden in the supervisor pending view. Vector writes cover the two reserved mode codes and also partial masks, where the merge alone makes a legal old value illegal.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;
  typedef enum logic [3:0] {
    SEL_MIE     = 4'd0,
    SEL_MIP     = 4'd1,
    SEL_MIDELEG = 4'd2,
    SEL_SIE     = 4'd3,
    SEL_SIP     = 4'd4,
    SEL_MEDELEG = 4'd5,
    SEL_MTVEC   = 4'd6,
    SEL_STVEC   = 4'd7
  } csr_sel_e;

  localparam int unsigned BIT_USIP = 0;
  localparam int unsigned BIT_SSIP = 1;
  localparam int unsigned BIT_MSIP = 3;
  localparam int unsigned BIT_STIP = 5;
  localparam int unsigned BIT_MTIP = 7;
  localparam int unsigned BIT_UEIP = 8;
  localparam int unsigned BIT_SEIP = 9;
  localparam int unsigned BIT_MEIP = 11;

  localparam int unsigned MASK_W   = 16;
  localparam int unsigned NUM_TVEC = 2;

  localparam logic [MASK_W-1:0] IRQ_S_SET =
    (16'd1 << BIT_SSIP) | (16'd1 << BIT_STIP) | (16'd1 << BIT_SEIP);
  localparam logic [MASK_W-1:0] IRQ_M_SET =
    (16'd1 << BIT_MSIP) | (16'd1 << BIT_MTIP) | (16'd1 << BIT_MEIP);
  localparam logic [MASK_W-1:0] IRQ_ALL_SET = IRQ_S_SET | IRQ_M_SET;
  localparam logic [MASK_W-1:0] SIP_SW_SET =
    (16'd1 << BIT_SSIP) | (16'd1 << BIT_USIP) | (16'd1 << BIT_UEIP);
  // causes 0..13 and 15; 14 is reserved
  localparam logic [MASK_W-1:0] EXC_DELEG_SET =
    ((16'd1 << 14) - 16'd1) | (16'd1 << 15);
endpackage

// File: rtl/irq_intr_regs.sv
module irq_intr_regs
  import irq_csr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  csr_sel_e        sel_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] wmask_i,
  input  logic [XLEN-1:0] hw_pend_i,
  input  logic [XLEN-1:0] claim_i,
  output logic [XLEN-1:0] mie_o,
  output logic [XLEN-1:0] mip_o,
  output logic [XLEN-1:0] mideleg_o
);
  localparam logic [XLEN-1:0] DELEG_M = XLEN'(IRQ_S_SET);
  localparam logic [XLEN-1:0] ALL_M   = XLEN'(IRQ_ALL_SET);
  localparam logic [XLEN-1:0] SWR_M   = XLEN'(SIP_SW_SET);

  logic [XLEN-1:0] mie_q, mip_q, mideleg_q;
  logic [XLEN-1:0] mie_d, mip_d, mideleg_d;
  logic [XLEN-1:0] sw_pmask, mip_sw, s_merged, sie_new;

  always_comb begin
    mie_d     = mie_q;
    mideleg_d = mideleg_q;
    sw_pmask  = '0;
    s_merged  = ((mie_q & mideleg_q) & ~wmask_i) | (wdata_i & wmask_i);
    sie_new   = (mie_q & ~mideleg_q) | (s_merged & mideleg_q);
    if (req_i) begin
      case (sel_i)
        SEL_MIE: mie_d = (mie_q & ~ALL_M) |
                         (((mie_q & ~wmask_i) | (wdata_i & wmask_i)) & ALL_M);
        SEL_MIDELEG: mideleg_d = (mideleg_q & ~DELEG_M) |
                         (((mideleg_q & ~wmask_i) | (wdata_i & wmask_i)) & DELEG_M);
        SEL_SIE: mie_d = (mie_q & ~ALL_M) | (sie_new & ALL_M);
        SEL_MIP: sw_pmask = wmask_i & DELEG_M & ~claim_i;
        SEL_SIP: sw_pmask = wmask_i & mideleg_q & SWR_M & DELEG_M & ~claim_i;
        default: ;
      endcase
    end
    mip_sw = (mip_q & ~sw_pmask) | (wdata_i & sw_pmask);
    // hardware owns claimed bits, software loses same-cycle races
    mip_d  = (mip_sw & ~claim_i) | (hw_pend_i & claim_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mie_q     <= '0;
      mip_q     <= '0;
      mideleg_q <= '0;
    end else begin
      mie_q     <= mie_d;
      mip_q     <= mip_d;
      mideleg_q <= mideleg_d;
    end
  end

  assign mie_o     = mie_q;
  assign mip_o     = mip_q;
  assign mideleg_o = mideleg_q;
endmodule

// File: rtl/irq_exc_deleg.sv
module irq_exc_deleg
  import irq_csr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] wmask_i,
  output logic [XLEN-1:0] q_o
);
  localparam logic [XLEN-1:0] EXC_M = XLEN'(EXC_DELEG_SET);

  logic [XLEN-1:0] q;
  logic [XLEN-1:0] merged;

  assign merged = (q & ~wmask_i) | (wdata_i & wmask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (wr_en_i) q <= (q & ~EXC_M) | (merged & EXC_M);
  end

  assign q_o = q;
endmodule

// File: rtl/irq_tvec_reg.sv
module irq_tvec_reg #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] wmask_i,
  output logic [XLEN-1:0] q_o
);
  logic [XLEN-1:0] q;
  logic [XLEN-1:0] merged;
  logic            mode_ok;

  assign merged  = (q & ~wmask_i) | (wdata_i & wmask_i);
  assign mode_ok = merged[1:0] < 2'd2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 q <= '0;
    else if (wr_en_i && mode_ok) q <= merged;
  end

  assign q_o = q;
endmodule

// File: rtl/irq_csr_bank.sv
module irq_csr_bank
  import irq_csr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [3:0]      sel_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] wmask_i,
  output logic [XLEN-1:0] rdata_o,
  input  logic [XLEN-1:0] hw_pend_i,
  input  logic [XLEN-1:0] claim_i,
  output logic [XLEN-1:0] mie_o,
  output logic [XLEN-1:0] mip_o,
  output logic [XLEN-1:0] mideleg_o,
  output logic [XLEN-1:0] medeleg_o,
  output logic [XLEN-1:0] mtvec_o,
  output logic [XLEN-1:0] stvec_o
);
  csr_sel_e        sel;
  logic [XLEN-1:0] tvec_q [NUM_TVEC];

  assign sel = csr_sel_e'(sel_i);

  irq_intr_regs #(.XLEN(XLEN)) u_intr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .sel_i     (sel),
    .wdata_i   (wdata_i),
    .wmask_i   (wmask_i),
    .hw_pend_i (hw_pend_i),
    .claim_i   (claim_i),
    .mie_o     (mie_o),
    .mip_o     (mip_o),
    .mideleg_o (mideleg_o)
  );

  irq_exc_deleg #(.XLEN(XLEN)) u_exc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (req_i && (sel == SEL_MEDELEG)),
    .wdata_i (wdata_i),
    .wmask_i (wmask_i),
    .q_o     (medeleg_o)
  );

  for (genvar g = 0; g < NUM_TVEC; g++) begin : g_tvec
    localparam csr_sel_e MY_SEL = (g == 0) ? SEL_MTVEC : SEL_STVEC;
    irq_tvec_reg #(.XLEN(XLEN)) u_tvec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (req_i && (sel == MY_SEL)),
      .wdata_i (wdata_i),
      .wmask_i (wmask_i),
      .q_o     (tvec_q[g])
    );
  end

  assign mtvec_o = tvec_q[0];
  assign stvec_o = tvec_q[1];

  always_comb begin
    case (sel)
      SEL_MIE:     rdata_o = mie_o;
      SEL_MIP:     rdata_o = mip_o;
      SEL_MIDELEG: rdata_o = mideleg_o;
      SEL_SIE:     rdata_o = mie_o & mideleg_o;
      SEL_SIP:     rdata_o = mip_o & mideleg_o;
      SEL_MEDELEG: rdata_o = medeleg_o;
      SEL_MTVEC:   rdata_o = tvec_q[0];
      SEL_STVEC:   rdata_o = tvec_q[1];
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_csr_bank_chk.sv
module irq_csr_bank_chk
  import irq_csr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic [3:0]      sel_i,
  input logic [XLEN-1:0] rdata_o,
  input logic [XLEN-1:0] hw_pend_i,
  input logic [XLEN-1:0] claim_i,
  input logic [XLEN-1:0] mie_o,
  input logic [XLEN-1:0] mip_o,
  input logic [XLEN-1:0] mideleg_o,
  input logic [XLEN-1:0] medeleg_o,
  input logic [XLEN-1:0] mtvec_o,
  input logic [XLEN-1:0] stvec_o
);
  localparam logic [XLEN-1:0] DELEG_M = XLEN'(IRQ_S_SET);
  localparam logic [XLEN-1:0] ALL_M   = XLEN'(IRQ_ALL_SET);
  localparam logic [XLEN-1:0] EXC_M   = XLEN'(EXC_DELEG_SET);

  assert_deleg_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mideleg_o & ~DELEG_M) == '0);

  assert_enable_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mie_o & ~ALL_M) == '0);

  assert_unclaimed_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ((mip_o & ~$past(claim_i)) == ($past(mip_o) & ~$past(claim_i))));

  assert_claim_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((mip_o & $past(claim_i)) == ($past(hw_pend_i) & $past(claim_i))));

  assert_sip_view_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 4'd4) |-> ((rdata_o & ~mideleg_o) == '0));

  assert_tvec_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mtvec_o[1:0] < 2'd2) && (stvec_o[1:0] < 2'd2));

  assert_exc_legal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (medeleg_o & ~EXC_M) == '0);

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(mie_o) && $stable(mideleg_o) && $stable(medeleg_o)
                && $stable(mtvec_o) && $stable(stvec_o)));

  assert_bad_sel_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i > 4'd7) |-> (rdata_o == '0));
endmodule

bind irq_csr_bank irq_csr_bank_chk #(.XLEN(XLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .sel_i     (sel_i),
  .rdata_o   (rdata_o),
  .hw_pend_i (hw_pend_i),
  .claim_i   (claim_i),
  .mie_o     (mie_o),
  .mip_o     (mip_o),
  .mideleg_o (mideleg_o),
  .medeleg_o (medeleg_o),
  .mtvec_o   (mtvec_o),
  .stvec_o   (stvec_o)
);

// File: tb/irq_csr_bank_test.sv
module irq_csr_bank_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int XLEN = 32;
  localparam logic [3:0] S_MIE = 4'd0, S_MIP = 4'd1, S_MID = 4'd2, S_SIE = 4'd3,
                         S_SIP = 4'd4, S_MED = 4'd5, S_MTV = 4'd6, S_STV = 4'd7;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req = 1'b0;
  logic [3:0]      sel = '0;
  logic [XLEN-1:0] wdata = '0, wmask = '0, hw = '0, claim = '0;
  logic [XLEN-1:0] rdata, mie, mip, mideleg, medeleg, mtvec, stvec;
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  irq_csr_bank #(.XLEN(XLEN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .sel_i(sel),
    .wdata_i(wdata), .wmask_i(wmask), .rdata_o(rdata),
    .hw_pend_i(hw), .claim_i(claim),
    .mie_o(mie), .mip_o(mip), .mideleg_o(mideleg), .medeleg_o(medeleg),
    .mtvec_o(mtvec), .stvec_o(stvec)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic rmw(input logic [3:0] s, input logic [31:0] wd, input logic [31:0] wm,
                     output logic [31:0] old);
    @(negedge clk);
    req = 1'b1; sel = s; wdata = wd; wmask = wm;
    #1 old = rdata;
    @(negedge clk);
    req = 1'b0; wmask = '0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [31:0] v);
    rmw(s, 32'h0, 32'h0, v);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), v);
      check("R1 reset read", v, 32'h0);
    end
  endtask

  task automatic t_deleg_enable;
    logic [31:0] v;
    rmw(S_MID, ONES, ONES, v);
    check("R2 old value returned", v, 32'h0);
    rd(S_MID, v);  check("R3 deleg legal bits", v, 32'h222);
    rmw(S_MIE, ONES, ONES, v);
    rd(S_MIE, v);  check("R4 enable legal bits", v, 32'hAAA);
    rmw(S_MIE, 32'h0, 32'h00F, v);
    check("R2 old enable", v, 32'hAAA);
    rd(S_MIE, v);  check("R2 partial mask merge", v, 32'hAA0);
    rmw(S_MIE, ONES, ONES, v);
  endtask

  task automatic t_sie;
    logic [31:0] v;
    rd(S_SIE, v);  check("R8 sie view", v, 32'h222);
    rmw(S_SIE, 32'h0, ONES, v);
    rd(S_MIE, v);  check("R8 sie clears delegated only", v, 32'h888);
    rmw(S_MID, 32'h0, ONES, v);
    rmw(S_SIE, ONES, ONES, v);
    check("R8 sie undelegated reads 0", v, 32'h0);
    rd(S_MIE, v);  check("R8 undelegated sie write ignored", v, 32'h888);
    rmw(S_MID, ONES, ONES, v);
    rmw(S_SIE, ONES, ONES, v);
    rd(S_MIE, v);  check("R8 sie sets delegated", v, 32'hAAA);
  endtask

  task automatic t_mip;
    logic [31:0] v;
    rmw(S_MIP, ONES, ONES, v);
    rd(S_MIP, v);  check("R5 sw pending delegable only", v, 32'h222);
    rmw(S_MIP, 32'h0, ONES, v);
    rd(S_MIP, v);  check("R5 sw pending clear", v, 32'h0);
    claim = 32'h200; hw = 32'h0;
    rmw(S_MIP, ONES, ONES, v);
    rd(S_MIP, v);  check("R5 claimed bit not sw writable", v, 32'h022);
  endtask

  task automatic t_claim;
    logic [31:0] v;
    hw = 32'h200;
    rd(S_MIP, v);  check("R6 claimed follows hw", v, 32'h222);
    rmw(S_MIP, 32'h0, ONES, v);
    rd(S_MIP, v);  check("R6 hw wins same cycle", v, 32'h200);
    hw = 32'h0;
    rd(S_MIP, v);  check("R6 claimed drops with hw", v, 32'h0);
    claim = 32'h880; hw = 32'h880;
    rd(S_MIP, v);  check("R6 non-delegable claimed bits", v, 32'h880);
    rd(S_SIP, v);  check("R7 sip hides machine bits", v, 32'h0);
    claim = 32'h0; hw = 32'h0;
    rd(S_MIP, v);
    rmw(S_MIP, 32'h0, ONES, v);
    rd(S_MIP, v);  check("R6 released bits keep value", v, 32'h880);
  endtask

  task automatic t_sip;
    logic [31:0] v;
    rmw(S_SIP, ONES, ONES, v);
    rd(S_MIP, v);  check("R7 sip writes only bit1", v, 32'h882);
    rmw(S_MIP, ONES, ONES, v);
    rmw(S_MID, 32'h020, ONES, v);
    rd(S_SIP, v);  check("R7 sip read masked", v, 32'h020);
    rmw(S_SIP, 32'h0, ONES, v);
    rd(S_MIP, v);  check("R7 undelegated sip write ignored", v, 32'hAA2);
  endtask

  task automatic t_tvec(input logic [3:0] s, input string nm);
    logic [31:0] v;
    rmw(s, 32'h1000_0001, ONES, v);
    rd(s, v);  check({"R9 vectored stored ", nm}, v, 32'h1000_0001);
    rmw(s, 32'h2000_0002, ONES, v);
    rd(s, v);  check({"R9 mode 2 discarded ", nm}, v, 32'h1000_0001);
    rmw(s, 32'h3000_0003, ONES, v);
    rd(s, v);  check({"R9 mode 3 discarded ", nm}, v, 32'h1000_0001);
    rmw(s, 32'h4000_0000, ONES, v);
    check({"R2 tvec old value ", nm}, v, 32'h1000_0001);
    rd(s, v);  check({"R9 direct stored ", nm}, v, 32'h4000_0000);
    rmw(s, 32'h2, 32'h3, v);
    rd(s, v);  check({"R9 merged illegal discarded ", nm}, v, 32'h4000_0000);
  endtask

  task automatic t_medeleg;
    logic [31:0] v;
    rmw(S_MED, ONES, ONES, v);
    rd(S_MED, v);  check("R10 exc deleg legal bits", v, 32'h0000_BFFF);
    rmw(S_MED, 32'h0, 32'h0000_0101, v);
    rd(S_MED, v);  check("R10 partial clear", v, 32'h0000_BEFE);
  endtask

  task automatic t_idle_badsel;
    logic [31:0] v;
    logic [31:0] mie_b, mid_b, med_b, mtv_b;
    mie_b = mie; mid_b = mideleg; med_b = medeleg; mtv_b = mtvec;
    rmw(4'hF, ONES, ONES, v);
    check("R11 bad select reads 0", v, 32'h0);
    rmw(4'h8, 32'h0, ONES, v);
    check("R11 bad select 8 reads 0", v, 32'h0);
    check("R11 enable unchanged", mie, mie_b);
    check("R11 deleg unchanged", mideleg, mid_b);
    check("R11 exc unchanged", medeleg, med_b);
    @(negedge clk);
    sel = S_MIE; wdata = 32'h0; wmask = ONES; req = 1'b0;
    @(negedge clk); @(negedge clk);
    wmask = '0;
    check("R2 no write without req", mie, mie_b);
    check("R2 vector unchanged", mtvec, mtv_b);
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_deleg_enable();
    t_sie();
    t_mip();
    t_claim();
    t_sip();
    t_tvec(S_MTV, "mtvec");
    t_tvec(S_STV, "stvec");
    t_medeleg();
    t_idle_badsel();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule